// File: doc/BRIEF.md
# Two-Level Time-Slot Bus Arbiter

This block decides which master may drive a shared on-chip bus in each bus cycle. A repeating wheel of time slots gives every slot one owning master. When the owner of the current slot is requesting, it gets the grant. When the owner is idle, the slot is not wasted. A second stage hands it to the requesting master with the lowest index, so master 0 has the highest priority there.

The decision is registered through a pipeline of `PIPE_DEPTH` stages. The grant for a bus cycle is therefore fixed that many cycles before the cycle is used. This lets the depth follow the latency the bus targets need at the chosen clock rate. The wheel is reprogrammed through a one-entry-per-cycle write port. New owners go into a staging copy, and the working copy takes them over only at the moment the wheel wraps.

Alongside the grant, the block reports two things for the bus cycle now being served: the slot index, and where the grant came from (slot owner, reclaimed slot, or idle).

Top module: `tdma_bus_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `grant_o` is all zero, `grant_src_o` is 0 and `slot_o` is 0.
- R2: When the owner of the slot being arbitrated requests, that owner alone is granted and `grant_src_o` reads 1.
- R3: When the owner of that slot does not request but others do, the requester with the lowest index is granted and `grant_src_o` reads 2.
- R4: When no master requests, `grant_o` is all zero and `grant_src_o` reads 0 (an idle slot).
- R5: `grant_o` never has more than one bit set.
- R6: The request vector sampled at clock edge e decides the grant driven after edge e+PIPE_DEPTH-1. Before the pipeline has filled after reset, the grant is zero.
- R7: Once filled, `slot_o` names the slot of the grant being driven. It rises by one every cycle and wraps from SLOTS-1 to 0, with arbitration starting at slot 0 on the first edge after reset.
- R8: A table write lands in a staging copy and is used only by arbitration that starts after the wheel next wraps (after the edge where slot SLOTS-1 is arbitrated). A write on that very edge is included.
- R9: Reset loads every slot s with owner s mod N_MASTERS, in both the staging and the working copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_MASTERS | One request line per master |
| tbl_wr_en_i | input | 1 | Write strobe for the slot table |
| tbl_wr_slot_i | input | SLOT_W | Slot entry being written |
| tbl_wr_owner_i | input | OWN_W | Master index stored in that entry |
| grant_o | output | N_MASTERS | One-hot grant for the current bus cycle, or zero |
| grant_src_o | output | 2 | 0 idle, 1 owner grant, 2 reclaimed slot |
| slot_o | output | SLOT_W | Slot index of the current bus cycle |

## Verification
The properties assume that requests are only meaningful at clock edges. A master's line is taken as its request for the slot being arbitrated at that edge, with nothing held over from earlier slots. The checker keeps its own delayed copy of the request lines to compare grants against. The bench changes inputs only on the falling edge. It holds each of the sixteen request patterns across a full rotation, then adds a single-cycle pulse and a pseudo-random stretch. Table writes are issued only through the write port, with owner indices inside the master range.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

    localparam int unsigned DEF_MASTERS = 4;
    localparam int unsigned DEF_SLOTS   = 16;
    localparam int unsigned DEF_DEPTH   = 2;

    // Origin of the grant carried through the pipeline.
    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_OWNER   = 2'd1,
        SRC_RECLAIM = 2'd2
    } grant_src_e;

    // Width needed to index n items, never below one bit.
    function automatic int unsigned idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdma_slot_table.sv
module tdma_slot_table
    import tdma_arb_pkg::*;
#(
    parameter int N_MASTERS = DEF_MASTERS,
    parameter int SLOTS     = DEF_SLOTS,
    parameter int SLOT_W    = idx_w(SLOTS),
    parameter int OWN_W     = idx_w(N_MASTERS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [OWN_W-1:0]  wr_owner,
    input  logic              commit,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [OWN_W-1:0]  rd_owner
);

    logic [OWN_W-1:0] working_view [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_entry
        localparam logic [OWN_W-1:0] INIT_OWNER = OWN_W'(s % N_MASTERS);

        logic [OWN_W-1:0] staged_q;
        logic [OWN_W-1:0] working_q;
        logic [OWN_W-1:0] staged_next;
        logic             hit;

        assign hit         = wr_en && (wr_slot == SLOT_W'(s));
        assign staged_next = hit ? wr_owner : staged_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                staged_q  <= INIT_OWNER;
                working_q <= INIT_OWNER;
            end else begin
                staged_q <= staged_next;
                if (commit) begin
                    working_q <= staged_next;
                end
            end
        end

        assign working_view[s] = working_q;
    end

    assign rd_owner = working_view[rd_slot];

endmodule

// File: rtl/tdma_pick.sv
module tdma_pick
    import tdma_arb_pkg::*;
#(
    parameter int N_MASTERS = DEF_MASTERS,
    parameter int OWN_W     = idx_w(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [OWN_W-1:0]     owner,
    output logic [N_MASTERS-1:0] grant,
    output grant_src_e           src
);

    logic owner_valid;

    assign owner_valid = int'(owner) < N_MASTERS;

    always_comb begin
        grant = '0;
        src   = SRC_IDLE;
        if (owner_valid && req[owner]) begin
            grant[owner] = 1'b1;
            src          = SRC_OWNER;
        end else begin
            // Scan from the top so the lowest requesting index wins.
            for (int i = N_MASTERS - 1; i >= 0; i--) begin
                if (req[i]) begin
                    grant    = '0;
                    grant[i] = 1'b1;
                    src      = SRC_RECLAIM;
                end
            end
        end
    end

endmodule

// File: rtl/tdma_grant_pipe.sv
module tdma_grant_pipe
    import tdma_arb_pkg::*;
#(
    parameter int N_MASTERS  = DEF_MASTERS,
    parameter int SLOT_W     = idx_w(DEF_SLOTS),
    parameter int PIPE_DEPTH = DEF_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] in_grant,
    input  grant_src_e           in_src,
    input  logic [SLOT_W-1:0]    in_slot,
    output logic [N_MASTERS-1:0] out_grant,
    output grant_src_e           out_src,
    output logic [SLOT_W-1:0]    out_slot
);

    typedef struct packed {
        logic [N_MASTERS-1:0] grant;
        grant_src_e           src;
        logic [SLOT_W-1:0]    slot;
    } stage_t;

    stage_t                  head;
    stage_t [PIPE_DEPTH-1:0] stage_q;

    assign head.grant = in_grant;
    assign head.src   = in_src;
    assign head.slot  = in_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= head;
            for (int d = 1; d < PIPE_DEPTH; d++) begin
                stage_q[d] <= stage_q[d-1];
            end
        end
    end

    assign out_grant = stage_q[PIPE_DEPTH-1].grant;
    assign out_src   = stage_q[PIPE_DEPTH-1].src;
    assign out_slot  = stage_q[PIPE_DEPTH-1].slot;

endmodule

// File: rtl/tdma_bus_arbiter.sv
module tdma_bus_arbiter
    import tdma_arb_pkg::*;
#(
    parameter  int N_MASTERS  = DEF_MASTERS,
    parameter  int SLOTS      = DEF_SLOTS,
    parameter  int PIPE_DEPTH = DEF_DEPTH,
    localparam int SLOT_W     = idx_w(SLOTS),
    localparam int OWN_W      = idx_w(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 tbl_wr_en_i,
    input  logic [SLOT_W-1:0]    tbl_wr_slot_i,
    input  logic [OWN_W-1:0]     tbl_wr_owner_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic [1:0]           grant_src_o,
    output logic [SLOT_W-1:0]    slot_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0]    arb_slot_q;
    logic                 wrap;
    logic [OWN_W-1:0]     slot_owner;
    logic [N_MASTERS-1:0] pick_grant;
    grant_src_e           pick_src;
    grant_src_e           pipe_src;

    // Slot whose grant is being decided this cycle.
    assign wrap = (arb_slot_q == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            arb_slot_q <= '0;
        end else begin
            arb_slot_q <= wrap ? '0 : arb_slot_q + 1'b1;
        end
    end

    tdma_slot_table #(
        .N_MASTERS (N_MASTERS),
        .SLOTS     (SLOTS),
        .SLOT_W    (SLOT_W),
        .OWN_W     (OWN_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr_en_i),
        .wr_slot  (tbl_wr_slot_i),
        .wr_owner (tbl_wr_owner_i),
        .commit   (wrap),
        .rd_slot  (arb_slot_q),
        .rd_owner (slot_owner)
    );

    tdma_pick #(
        .N_MASTERS (N_MASTERS),
        .OWN_W     (OWN_W)
    ) u_pick (
        .req   (req_i),
        .owner (slot_owner),
        .grant (pick_grant),
        .src   (pick_src)
    );

    tdma_grant_pipe #(
        .N_MASTERS  (N_MASTERS),
        .SLOT_W     (SLOT_W),
        .PIPE_DEPTH (PIPE_DEPTH)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_grant  (pick_grant),
        .in_src    (pick_src),
        .in_slot   (arb_slot_q),
        .out_grant (grant_o),
        .out_src   (pipe_src),
        .out_slot  (slot_o)
    );

    assign grant_src_o = pipe_src;

endmodule

// File: rtl/tdma_bus_arbiter_chk.sv
module tdma_bus_arbiter_chk #(
    parameter int N_MASTERS  = 4,
    parameter int SLOTS      = 16,
    parameter int PIPE_DEPTH = 2,
    parameter int SLOT_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req_i,
    input logic [N_MASTERS-1:0] grant_o,
    input logic [1:0]           grant_src_o,
    input logic [SLOT_W-1:0]    slot_o
);

    logic [PIPE_DEPTH-1:0][N_MASTERS-1:0] hist_q;
    int unsigned                          run_q = 0;
    logic                                 filled;
    logic [N_MASTERS-1:0]                 aged_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            run_q  <= 0;
        end else begin
            hist_q[0] <= req_i;
            for (int d = 1; d < PIPE_DEPTH; d++) begin
                hist_q[d] <= hist_q[d-1];
            end
            if (run_q < PIPE_DEPTH) begin
                run_q <= run_q + 1;
            end
        end
    end

    assign filled   = (run_q == PIPE_DEPTH);
    assign aged_req = hist_q[PIPE_DEPTH-1];

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (grant_o == '0 && grant_src_o == 2'd0 && slot_o == '0));

    p_grant_requested_r2: assert property (@(posedge clk) disable iff (rst)
        filled |-> ((grant_o & ~aged_req) == '0));

    p_src_matches_r3: assert property (@(posedge clk) disable iff (rst)
        (grant_src_o == 2'd0) == (grant_o == '0));

    p_idle_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (filled && aged_req == '0) |-> (grant_o == '0 && grant_src_o == 2'd0));

    p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_fill_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !filled |-> (grant_o == '0));

    p_slot_step_r7: assert property (@(posedge clk) disable iff (rst)
        (filled && $past(filled)) |->
            (slot_o == (($past(slot_o) == SLOT_W'(SLOTS - 1)) ? '0 : $past(slot_o) + 1'b1)));

endmodule

bind tdma_bus_arbiter tdma_bus_arbiter_chk #(
    .N_MASTERS  (N_MASTERS),
    .SLOTS      (SLOTS),
    .PIPE_DEPTH (PIPE_DEPTH),
    .SLOT_W     (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .grant_o     (grant_o),
    .grant_src_o (grant_src_o),
    .slot_o      (slot_o)
);

// File: tb/tdma_bus_arbiter_test.sv
module tdma_bus_arbiter_test;

    localparam int N  = 4;
    localparam int S  = 16;
    localparam int D  = 2;
    localparam int SW = 4;
    localparam int MW = 2;
    localparam int HMAX = 4096;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req;
    logic          we;
    logic [SW-1:0] waddr;
    logic [MW-1:0] wown;
    logic [N-1:0]  grant;
    logic [1:0]    src;
    logic [SW-1:0] slot;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int k;
    int m_staged [S];
    int m_work [S];
    int dec_g [HMAX];
    int dec_src [HMAX];
    int dec_slot [HMAX];
    logic [7:0] lf;

    always #5 clk = ~clk;

    tdma_bus_arbiter #(.N_MASTERS(N), .SLOTS(S), .PIPE_DEPTH(D)) uut (
        .clk            (clk),
        .rst            (rst),
        .req_i          (req),
        .tbl_wr_en_i    (we),
        .tbl_wr_slot_i  (waddr),
        .tbl_wr_owner_i (wown),
        .grant_o        (grant),
        .grant_src_o    (src),
        .slot_o         (slot)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        k = 0;
        for (int s = 0; s < S; s++) begin
            m_staged[s] = s % N;
            m_work[s]   = s % N;
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 grant"}, int'(grant), 0);
        chk({tag, " R1 source"}, int'(src), 0);
        chk({tag, " R1 slot"}, int'(slot), 0);
    endtask

    // Drive one cycle on the falling edge, model the rising edge, check on the next falling edge.
    task automatic step(input logic [N-1:0] r, input bit w, input int a, input int o, input string ph);
        int sl;
        int own;
        int idx;
        int eg;
        int es;
        int esl;
        string rq;
        req   = r;
        we    = w;
        waddr = SW'(a);
        wown  = MW'(o);
        @(posedge clk);
        sl  = k % S;
        own = m_work[sl];
        if (r[own]) begin
            dec_g[k]   = 1 << own;
            dec_src[k] = 1;
        end else begin
            dec_g[k]   = 0;
            dec_src[k] = 0;
            for (int i = N - 1; i >= 0; i--) begin
                if (r[i]) begin
                    dec_g[k]   = 1 << i;
                    dec_src[k] = 2;
                end
            end
        end
        dec_slot[k] = sl;
        if (w) m_staged[a] = o;
        if (sl == S - 1) begin
            for (int s = 0; s < S; s++) m_work[s] = m_staged[s];
        end
        k++;
        @(negedge clk);
        idx = k - D;
        if (idx >= 0) begin
            eg = dec_g[idx]; es = dec_src[idx]; esl = dec_slot[idx];
        end else begin
            eg = 0; es = 0; esl = 0;
        end
        rq = (idx < 0) ? "R6 fill" : (es == 1) ? "R2 owner" : (es == 2) ? "R3 reclaim" : "R4 idle";
        chk({ph, " ", rq, " grant"}, int'(grant), eg);
        chk({ph, " ", rq, " source"}, int'(src), es);
        chk({ph, " R7 slot"}, int'(slot), esl);
        chk({ph, " R5 onehot"}, ($countones(grant) <= 1) ? 1 : 0, 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; we = 1'b0; waddr = '0; wown = '0;
        repeat (3) @(negedge clk);
        check_reset_state("reset hold");
        rst = 1'b0;
        model_reset();

        // Sweep every request pattern over a full rotation with the default owners (R9).
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < S; c++) step(N'(p), 1'b0, 0, 0, "R9 sweep");
        end

        // Single-cycle request pulse: visible exactly D-1 edges later (R6).
        for (int c = 0; c < 3; c++) step('0, 1'b0, 0, 0, "R6 quiet");
        step(4'b0100, 1'b0, 0, 0, "R6 pulse");
        for (int c = 0; c < 4; c++) step('0, 1'b0, 0, 0, "R6 after");

        // Reprogram mid-rotation with everyone requesting; owners must change only after a wrap (R8).
        step(4'b1111, 1'b1, 3, 0, "R8 write");
        step(4'b1111, 1'b1, 9, 2, "R8 write");
        step(4'b1111, 1'b1, 1, 3, "R8 write");
        for (int c = 0; c < 2 * S; c++) step(4'b1111, 1'b0, 0, 0, "R8 run");
        for (int c = 0; c < S; c++) step(4'b1110, (c == S - 1 - (k % S)), 5, 0, "R8 owner-idle");
        lf = 8'h5a;
        for (int c = 0; c < 3 * S; c++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[3:0], lf[7], int'(lf[6:3]), int'(lf[1:0]), "R8 mixed");
        end

        // Reset in mid-run: outputs clear and the default table returns (R1, R9).
        @(negedge clk);
        rst = 1'b1; req = 4'b1111;
        @(negedge clk);
        check_reset_state("mid-run");
        rst = 1'b0;
        model_reset();
        for (int c = 0; c < S + D; c++) step(4'b1110, 1'b0, 0, 0, "R9 after reset");
        for (int c = 0; c < S; c++) step(4'b0001, 1'b0, 0, 0, "R9 after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule